// File: doc/BRIEF.md
# Serial Vote Report Framer

This block turns one decoded vote into a short asynchronous serial report for a host. A vote is a button number and a 24-bit transmitter ID. The block sends them as five bytes in a fixed order: the button number, then the three ID bytes, then a checksum byte.

Each byte goes out as a character with a low start bit, eight data bits and a high stop bit. The bytes follow each other with no idle time between them. The line rests high between reports. The bit time is set by the parameter `BIT_CYCLES`, which is the number of clock cycles per bit. The default of 13021 gives 19,200 bits per second from a 250 MHz clock.

The request side is a valid/ready handshake:
- A vote is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` stays low for the whole report. A request held during that time waits and is taken once the report ends.
- A request offered for only a few cycles while a report is being sent is dropped. It has no effect on the report in progress.
- `busy` is a plain status pin that shows a report is being sent.

Top module: `vote_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `req_ready` is 1.
- R2: A vote is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `busy` is 1 in the cycle that follows, and `req_ready` equals the inverse of `busy` at all times.
- R3: Each byte is sent as ten symbols, each lasting exactly `BIT_CYCLES` clock cycles: first a start symbol of 0, then data bits 0 to 7 in that order (least significant bit first), then a stop symbol of 1. The start symbol of the first byte appears in the cycle right after the accepting edge.
- R4: The bytes go out in this order: byte 0 is `req_button`, byte 1 is `req_id[23:16]`, byte 2 is `req_id[15:8]`, byte 3 is `req_id[7:0]`, and byte 4 is the checksum.
- R5: The checksum is the sum of bytes 0 to 3 modulo 256. Any carry out of bit 7 is dropped.
- R6: While `busy` is 1, `req_ready` is 0. A request offered during that time does not change any symbol of the report in progress.
- R7: `busy` stays 1 for exactly 50 × `BIT_CYCLES` cycles, which is the end of the last stop symbol, and then falls. Whenever `busy` is 0, `txd` is 1.
- R8: The start symbol of each byte comes straight after the stop symbol of the byte before it, with no idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A vote is offered |
| req_ready | output | 1 | The block can accept a vote |
| req_button | input | 8 | Button number of the vote |
| req_id | input | 24 | Transmitter ID of the vote |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | A report is being sent |

## Verification
Most internal faults show up on `txd` within the same report. A wrong bit counter or symbol timer moves a symbol edge, and the check on symbol boundaries sees it within one bit time. A wrong byte queue or checksum gives a wrong decoded byte once the bench reads the full report. A fault in the sequencer's byte count changes how long `busy` stays high, which is visible as soon as the report should have ended. If the request guard is broken, the repeated requests the bench sends during a report change the rest of that report.

// File: rtl/vote_frame_pkg.sv
package vote_frame_pkg;
  localparam int BYTE_W      = 8;
  localparam int ID_BYTES    = 3;
  localparam int ID_W        = BYTE_W * ID_BYTES;
  localparam int FRAME_BYTES = ID_BYTES + 2;          // button, id bytes, checksum
  localparam int SYM_PER_BYTE = BYTE_W + 2;           // start, data, stop
  localparam int FRAME_SYMS  = FRAME_BYTES * SYM_PER_BYTE;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t frame_sum(input byte_t btn, input logic [ID_W-1:0] id);
    byte_t acc;
    acc = btn;
    for (int i = 0; i < ID_BYTES; i++) acc = acc + id[i*BYTE_W +: BYTE_W];
    return acc;
  endfunction
endpackage

// File: rtl/vft_bit_timer.sv
module vft_bit_timer #(
  parameter int BIT_CYCLES = 13021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vft_char_shifter.sv
module vft_char_shifter
  import vote_frame_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_byte,
  input  logic  tick,
  output logic  txd,
  output logic  sym_done
);
  localparam int BC_W = $clog2(SYM_PER_BYTE);
  localparam logic [BC_W-1:0] LAST_SYM = BC_W'(SYM_PER_BYTE - 1);

  logic [SYM_PER_BYTE-1:0] sh_q;
  logic [BC_W-1:0]         bc_q;

  assign txd      = sh_q[0];
  assign sym_done = tick && (bc_q == LAST_SYM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
      bc_q <= '0;
    end else if (load) begin
      sh_q <= {1'b1, load_byte, 1'b0};
      bc_q <= '0;
    end else if (tick && !sym_done) begin
      sh_q <= {1'b1, sh_q[SYM_PER_BYTE-1:1]};
      bc_q <= bc_q + 1'b1;
    end
  end
endmodule

// File: rtl/vft_frame_seq.sv
module vft_frame_seq
  import vote_frame_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  byte_t           req_button,
  input  logic [ID_W-1:0] req_id,
  input  logic            sym_done,
  output logic            load,
  output byte_t           load_byte,
  output logic            busy
);
  localparam int LEFT_W = $clog2(FRAME_BYTES + 1);

  byte_t             que_q [FRAME_BYTES];
  byte_t             fill  [FRAME_BYTES];
  logic [LEFT_W-1:0] left_q;
  logic              busy_q;
  logic              accept;
  logic              advance;

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign accept    = req_valid && !busy_q;
  assign advance   = sym_done && (left_q > LEFT_W'(1));
  assign load      = accept || advance;
  assign load_byte = accept ? req_button : que_q[1];

  // Fill order: button, ID most significant byte first, checksum last.
  always_comb begin
    fill[0] = req_button;
    for (int i = 0; i < ID_BYTES; i++)
      fill[1+i] = req_id[(ID_BYTES-1-i)*BYTE_W +: BYTE_W];
    fill[FRAME_BYTES-1] = frame_sum(req_button, req_id);
  end

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_que
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        que_q[g] <= '0;
      else if (accept)   que_q[g] <= fill[g];
      else if (advance)  que_q[g] <= (g + 1 < FRAME_BYTES) ? que_q[(g+1) % FRAME_BYTES] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      left_q <= LEFT_W'(FRAME_BYTES);
    end else if (sym_done) begin
      left_q <= left_q - 1'b1;
      if (left_q == LEFT_W'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vote_frame_tx.sv
module vote_frame_tx
  import vote_frame_pkg::*;
#(
  parameter int BIT_CYCLES = 13021
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [7:0]      req_button,
  input  logic [23:0]     req_id,
  output logic            txd,
  output logic            busy
);
  logic  tick, sym_done, load;
  byte_t load_byte;

  vft_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_button (req_button),
    .req_id     (req_id),
    .sym_done   (sym_done),
    .load       (load),
    .load_byte  (load_byte),
    .busy       (busy)
  );

  vft_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  vft_char_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (load_byte),
    .tick      (tick),
    .txd       (txd),
    .sym_done  (sym_done)
  );
endmodule

// File: rtl/vote_frame_tx_chk.sv
module vote_frame_tx_chk #(
  parameter int BIT_CYCLES = 13021
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic txd,
  input logic busy
);
  localparam int FRAME_CYC = 50 * BIT_CYCLES;
  localparam int LEN_W = $clog2(FRAME_CYC + 2);
  localparam int PH_W  = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;

  logic [LEN_W-1:0] len_q;
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ph_q  <= '0;
    end else begin
      len_q <= busy ? len_q + 1'b1 : '0;
      if (req_valid && req_ready) ph_q <= '0;
      else if (busy) ph_q <= (ph_q == PH_W'(BIT_CYCLES - 1)) ? '0 : ph_q + 1'b1;
      else ph_q <= '0;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R2
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R7
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R3
  AST_SYM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph_q != '0) |-> $stable(txd)); // R3
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q < LEN_W'(FRAME_CYC))); // R7
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == LEN_W'(FRAME_CYC))); // R7
endmodule

bind vote_frame_tx vote_frame_tx_chk #(.BIT_CYCLES(BIT_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .txd       (txd),
  .busy      (busy)
);

// File: tb/vote_frame_tx_tb.sv
module vote_frame_tx_tb;
  localparam int B = 4;
  localparam int NSYM = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_button = '0;
  logic [23:0] req_id = '0;
  logic req_ready, txd, busy;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vote_frame_tx #(.BIT_CYCLES(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_button(req_button), .req_id(req_id), .txd(txd), .busy(busy)
  );

  function automatic logic [7:0] exp_byte(int j, logic [7:0] b, logic [23:0] id);
    case (j)
      0: return b;
      1: return id[23:16];
      2: return id[15:8];
      3: return id[7:0];
      default: return 8'(b + id[23:16] + id[15:8] + id[7:0]);
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, logic [23:0] id, bit spam);
    logic sym [NSYM];
    bit busy_ok = 1;
    bit rdy_ok = 1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_button = b; req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    for (int n = 0; n < NSYM * B; n++) begin
      if (n % B == B / 2) sym[n / B] = txd;
      if (busy !== 1'b1) busy_ok = 0;
      if (req_ready !== 1'b0) rdy_ok = 0;
      if (spam && n > B && n < 40 * B) begin
        req_valid = $urandom_range(0, 1);
        req_button = 8'($urandom); req_id = 24'($urandom);
      end else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy_ok, "R7", "busy held for whole report", busy_ok, 1);
    chk(rdy_ok, "R6", "ready low while busy", rdy_ok, 1);
    chk(busy == 1'b0 && txd == 1'b1, "R7", "busy low and line high at end", {busy, txd}, 1);
    for (int j = 0; j < 5; j++) begin
      logic [7:0] got;
      for (int k = 0; k < 8; k++) got[k] = sym[j*10 + 1 + k];
      chk(sym[j*10] == 1'b0 && sym[j*10+9] == 1'b1, "R3", "start/stop symbols",
          {sym[j*10], sym[j*10+9]}, 1);
      chk(got == exp_byte(j, b, id), j == 4 ? "R5" : "R4", $sformatf("byte %0d", j),
          got, exp_byte(j, b, id));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && req_ready == 1'b1, "R1", "reset state",
        {txd, busy, req_ready}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && req_ready == 1'b1, "R1", "idle after reset",
        {txd, busy, req_ready}, 3'b101);
    // R4 example vote, R5 carry dropped, R3 all-zero and all-one patterns
    send(8'd5, 24'h00D915, 0);
    send(8'hFF, 24'hFFFFFF, 0);
    send(8'h00, 24'h000000, 0);
    send(8'h80, 24'h808080, 1);   // R6 requests during report
    // R8: back-to-back reports, no idle symbols between bytes (checked by decode)
    for (int i = 0; i < 30; i++)
      send(8'($urandom), 24'($urandom), i % 3 == 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule